// File: doc/BRIEF.md
# Serial PHY Management Frame Engine

This block is a management-bus master that sends one clause-22 style read or write frame to an external PHY each time software writes a command word. Software first sets a clock-divider value in a speed register. It then writes one 32-bit command word. That word carries the start pattern, the opcode, the PHY and register addresses, the turnaround bits and, for a write, 16 data bits. The engine drives a full 32-bit preamble of ones on the data line, then shifts the command word out MSB first, with a management clock derived from the system clock.

On a read, the engine stops driving the data line from the turnaround bits onward. It samples the PHY's answer on each rising management-clock edge. When the frame ends, the received value replaces the low 16 bits of the same command register. Completion raises a sticky event flag, which software polls and clears by writing a one to its bit. The engine has no busy indication: software waits for the event flag before it issues the next command. All register access pins are plain single-cycle write strobes with live read-back. No data stream passes through the block, so it has no valid/ready channel and applies no back-pressure.

Top module: `mgmt_frame_engine`

## Requirements
- R1: After reset, the management clock and the data-line enable are low, the event flag is clear, and the command and speed registers read zero.
- R2: A command write accepted while idle produces exactly one frame: 32 preamble bits of one, then the 32-bit command word MSB first. The data line changes only while the clock is low, one bit per clock period.
- R3: The speed value is held in bits [SPD_W:1] of the speed register. While a frame runs, the management clock has a period of 2×speed system cycles, low for the first half of each bit. Between frames the clock stays low.
- R4: While the speed value is zero, command writes are ignored: the command register keeps its value, no clock edge appears, and no event is raised.
- R5: The event flag (bit EVT_BIT of the event word) becomes set exactly 128×speed system cycles after the edge that accepted the command, and stays set until cleared.
- R6: Writing a one to bit EVT_BIT of the event-clear port clears the flag. Writing a zero there leaves the flag unchanged. A completion in the same cycle wins over a clear.
- R7: A command with opcode bits [29:28] = 10 is a read. The data-line enable drops from frame bit 14 (the first turnaround bit) to the end of the frame. The input is sampled at each clock rise of frame bits 16 to 31, and at completion the 16 sampled bits, first one in bit 15, replace command bits [15:0]. Bits [31:16] are kept.
- R8: Any other opcode, including 01 for a write, drives the data line for all 64 bits and leaves the command register unchanged at completion.
- R9: A command write during a frame is ignored. The register read-back and the frame on the wire are unchanged, and only one event is raised.
- R10: A speed write during a frame is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word: ST[31:30], OP[29:28], PHY[27:23], REG[22:18], TA[17:16], DATA[15:0] |
| cmd_rdata | output | 32 | Command register read-back, including read data |
| spd_we | input | 1 | Speed register write strobe |
| spd_wdata | input | 32 | Speed word, value in bits [SPD_W:1] |
| spd_rdata | output | 32 | Speed register read-back |
| evt_clr_we | input | 1 | Event register write strobe (write one to clear) |
| evt_clr_wdata | input | 32 | Event clear word, flag at bit EVT_BIT |
| evt_rdata | output | 32 | Event register read-back, flag at bit EVT_BIT |
| mdc | output | 1 | Management clock toward the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input from the pad |

## Verification
The engine accepts a command on the edge where the strobe is sampled. Each frame bit then takes 2×speed cycles, and the management clock rises `speed` cycles into each bit. The bench drives strobes on falling system-clock edges, records the cycle number of the accepting edge, and compares the event flag one cycle before and at exactly 128×speed cycles later. A monitor waits for each management-clock rise, samples the data line and its enable half a system cycle later, and checks the period against 2×speed. Read-back of the command register is checked after the completion edge, so the read data is compared only once it has been written.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int TOTAL_BITS = PRE_BITS + FRAME_BITS;
  localparam int TA_IDX     = 14;   // serial index of first turnaround bit
  localparam int DAT_IDX    = 16;   // serial index of first data bit
  localparam int RD_W       = 16;
  localparam int OP_HI      = 29;
  localparam int OP_LO      = 28;
  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mgmt_clkdiv.sv
module mgmt_clkdiv #(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SPD_W-1:0] spd,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [SPD_W-1:0] cnt;
  logic             tick;

  assign tick = run && (cnt == spd - SPD_W'(1));
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + SPD_W'(1);
    end
  end
endmodule

// File: rtl/mgmt_shifter.sv
module mgmt_shifter
  import mgmt_pkg::*;
#(
  parameter int CMD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             rise,
  input  logic             fall,
  input  logic             mdio_i,
  output logic             busy,
  output logic             done,
  output logic             is_read,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [RD_W-1:0]  rd_data
);
  localparam int CNT_W = $clog2(TOTAL_BITS);

  logic [CNT_W-1:0] bitcnt;
  logic [CMD_W-1:0] sh;
  logic             in_frame;

  assign in_frame = bitcnt >= CNT_W'(PRE_BITS);
  assign done     = busy && fall && (bitcnt == CNT_W'(TOTAL_BITS - 1));
  assign mdio_o   = busy ? (in_frame ? sh[CMD_W-1] : 1'b1) : 1'b1;
  assign mdio_oe  = busy && !(is_read && (bitcnt >= CNT_W'(PRE_BITS + TA_IDX)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_read <= 1'b0;
      bitcnt  <= '0;
      sh      <= '0;
      rd_data <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      is_read <= (cmd_word[OP_HI:OP_LO] == OP_READ);
      bitcnt  <= '0;
      sh      <= cmd_word;
      rd_data <= '0;
    end else if (busy) begin
      if (rise && is_read && (bitcnt >= CNT_W'(PRE_BITS + DAT_IDX)))
        rd_data <= {rd_data[RD_W-2:0], mdio_i};
      if (fall) begin
        if (done) begin
          busy   <= 1'b0;
          bitcnt <= '0;
        end else begin
          bitcnt <= bitcnt + CNT_W'(1);
          if (in_frame) sh <= {sh[CMD_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mgmt_evt.sv
module mgmt_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SPD_W   = 6,
  parameter int EVT_BIT = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] cmd_rdata,
  input  logic              spd_we,
  input  logic [DATA_W-1:0] spd_wdata,
  output logic [DATA_W-1:0] spd_rdata,
  input  logic              evt_clr_we,
  input  logic [DATA_W-1:0] evt_clr_wdata,
  output logic [DATA_W-1:0] evt_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int SPD_PAD = DATA_W - SPD_W - 1;

  logic [DATA_W-1:0] cmd_q;
  logic [SPD_W-1:0]  spd_q;
  logic              busy, done, is_read, rise, fall, evt_q, clr_hit, accept;
  logic [RD_W-1:0]   rd_data;
  logic              unused_bits;

  assign unused_bits = ^{spd_wdata[DATA_W-1:SPD_W+1], spd_wdata[0], evt_clr_wdata};
  assign accept  = cmd_we && !busy && (spd_q != '0);
  assign clr_hit = evt_clr_we && evt_clr_wdata[EVT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      spd_q <= '0;
    end else begin
      if (accept)
        cmd_q <= cmd_wdata;
      else if (done && is_read)
        cmd_q[RD_W-1:0] <= rd_data;
      if (spd_we && !busy)
        spd_q <= spd_wdata[SPD_W:1];
    end
  end

  assign cmd_rdata = cmd_q;
  assign spd_rdata = {{SPD_PAD{1'b0}}, spd_q, 1'b0};
  assign evt_rdata = DATA_W'(evt_q) << EVT_BIT;

  mgmt_clkdiv #(.SPD_W(SPD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .spd(spd_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mgmt_shifter #(.CMD_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(accept), .cmd_word(cmd_wdata),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .busy(busy), .done(done),
    .is_read(is_read), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
  );

  mgmt_evt u_evt (
    .clk(clk), .rst_n(rst_n), .set(done), .clr(clr_hit), .flag(evt_q)
  );
endmodule

// File: rtl/mgmt_frame_engine_chk.sv
module mgmt_frame_engine_chk #(
  parameter int DATA_W = 32,
  parameter int SPD_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              busy,
  input logic              done,
  input logic              is_read,
  input logic              evt_q,
  input logic              clr_hit,
  input logic [SPD_W-1:0]  spd_q,
  input logic [DATA_W-1:0] cmd_rdata
);
  assert_idle_clock_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  assert_data_steady_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |=> (!mdc || $stable(mdio_o)));
  assert_zero_speed_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_q == '0) |-> (!busy && !mdc));
  assert_event_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !clr_hit) |=> evt_q);
  assert_event_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !done) |=> !evt_q);
  assert_release_only_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |-> is_read);
  assert_cmd_held_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(cmd_rdata));
  assert_speed_held_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(spd_q));
endmodule

bind mgmt_frame_engine mgmt_frame_engine_chk #(.DATA_W(DATA_W), .SPD_W(SPD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .done(done), .is_read(is_read), .evt_q(evt_q), .clr_hit(clr_hit),
  .spd_q(spd_q), .cmd_rdata(cmd_rdata)
);

// File: tb/mgmt_frame_engine_bench.sv
module mgmt_frame_engine_bench;
  localparam int EVT_BIT = 23;

  typedef struct { logic oe; logic o; int per; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, spd_we = 0, evt_clr_we = 0, mdio_i = 1'b1;
  logic [31:0] cmd_wdata = '0, spd_wdata = '0, evt_clr_wdata = '0;
  logic [31:0] cmd_rdata, spd_rdata, evt_rdata;
  logic mdc, mdio_o, mdio_oe;

  int checks = 0, fails = 0, cyc = 0, rise_cnt = 0, last_rise = 0, e0 = 0;
  logic [15:0] reply = '0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mgmt_frame_engine #(.EVT_BIT(EVT_BIT)) u_mgmt_frame_engine (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .spd_we(spd_we), .spd_wdata(spd_wdata),
    .spd_rdata(spd_rdata), .evt_clr_we(evt_clr_we), .evt_clr_wdata(evt_clr_wdata),
    .evt_rdata(evt_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected bit per MDC rise
  always @(posedge mdc) begin
    int now;
    now = cyc;
    rise_cnt = rise_cnt + 1;
    @(negedge clk);
    if (q.size() == 0) begin
      chk("R2/R4/R9 unexpected clock edge", 32'd1, 32'd0);
    end else begin
      exp_t e;
      e = q.pop_front();
      chk("R2/R7/R8 data enable", {31'd0, mdio_oe}, {31'd0, e.oe});
      if (e.oe) chk("R2 data bit", {31'd0, mdio_o}, {31'd0, e.o});
      if (e.per != 0) chk("R3 clock period", now - last_rise, e.per);
    end
    last_rise = now;
  end

  // PHY model: presents read data after each falling MDC edge
  always @(negedge mdc) begin
    if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i = reply[63 - rise_cnt];
    else mdio_i = 1'b1;
  end

  task automatic pulse_cmd(input logic [31:0] w);
    @(negedge clk); cmd_wdata = w; cmd_we = 1;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic pulse_spd(input int s);
    @(negedge clk); spd_wdata = 32'(s) << 1; spd_we = 1;
    @(negedge clk); spd_we = 0;
  endtask

  task automatic pulse_clr(input logic [31:0] w);
    @(negedge clk); evt_clr_wdata = w; evt_clr_we = 1;
    @(negedge clk); evt_clr_we = 0;
  endtask

  // driver: pushes the expected frame, then launches it
  task automatic launch(input logic [31:0] w, input int spd, input logic [15:0] rsp);
    logic rd;
    rd = (w[29:28] == 2'b10);
    reply = rsp;
    rise_cnt = 0;
    for (int i = 0; i < 64; i++) begin
      exp_t e;
      e.oe  = !(rd && i >= 46);
      e.o   = (i < 32) ? 1'b1 : w[63 - i];
      e.per = (i == 0) ? 0 : 2 * spd;
      q.push_back(e);
    end
    @(negedge clk); cmd_wdata = w; cmd_we = 1;
    @(negedge clk); cmd_we = 0; e0 = cyc;
  endtask

  task automatic finish_frame(input int spd);
    while (cyc < e0 + 128 * spd - 1) @(negedge clk);
    chk("R5 event not early", evt_rdata, 32'd0);
    @(negedge clk);
    chk("R5 event on time", evt_rdata, 32'd1 << EVT_BIT);
    repeat (4) @(negedge clk);
    chk("R2 single frame", 32'(q.size()), 32'd0);
  endtask

  initial begin
    logic [31:0] w1, w2;
    repeat (3) @(negedge clk);
    chk("R1 mdc", {31'd0, mdc}, 32'd0);
    chk("R1 oe", {31'd0, mdio_oe}, 32'd0);
    chk("R1 event", evt_rdata, 32'd0);
    chk("R1 cmd", cmd_rdata, 32'd0);
    chk("R1 speed", spd_rdata, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4: zero speed ignores command
    pulse_cmd(32'h5002_A5A5);
    repeat (300) @(negedge clk);
    chk("R4 cmd unchanged", cmd_rdata, 32'd0);
    chk("R4 no event", evt_rdata, 32'd0);
    chk("R4 clock idle", {31'd0, mdc}, 32'd0);

    // R3: speed field placement
    pulse_spd(2);
    chk("R3 speed readback", spd_rdata, 32'd4);

    // R8: write frame, op 01
    w1 = {2'b01, 2'b01, 5'd3, 5'd17, 2'b10, 16'hC35A};
    launch(w1, 2, 16'h0);
    finish_frame(2);
    chk("R8 cmd kept", cmd_rdata, w1);

    // R6: W1C behaviour
    pulse_clr(32'hFFFF_FFFF ^ (32'd1 << EVT_BIT));
    chk("R6 zero write keeps flag", evt_rdata, 32'd1 << EVT_BIT);
    pulse_clr(32'd1 << EVT_BIT);
    chk("R6 one write clears", evt_rdata, 32'd0);

    // R7: read frame, op 10
    w2 = {2'b01, 2'b10, 5'd1, 5'd2, 2'b10, 16'h0000};
    launch(w2, 2, 16'hBEEF);
    finish_frame(2);
    chk("R7 read data", cmd_rdata, {w2[31:16], 16'hBEEF});
    pulse_clr(32'd1 << EVT_BIT);

    // R3/R7 at another speed
    pulse_spd(3);
    w2 = {2'b01, 2'b10, 5'd31, 5'd0, 2'b10, 16'hFFFF};
    launch(w2, 3, 16'h1234);
    finish_frame(3);
    chk("R7 read data speed 3", cmd_rdata, {w2[31:16], 16'h1234});
    pulse_clr(32'd1 << EVT_BIT);

    // R9/R10: writes during a frame are ignored
    w1 = {2'b01, 2'b01, 5'd7, 5'd9, 2'b10, 16'h0F0F};
    launch(w1, 3, 16'h0);
    repeat (20) @(negedge clk);
    pulse_cmd(32'h6FFF_FFFF);
    chk("R9 cmd held", cmd_rdata, w1);
    pulse_spd(1);
    chk("R10 speed held", spd_rdata, 32'd6);
    finish_frame(3);
    chk("R9 cmd after frame", cmd_rdata, w1);
    pulse_clr(32'd1 << EVT_BIT);
    repeat (20) @(negedge clk);
    chk("R9 one event only", evt_rdata, 32'd0);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule